// File: doc/BRIEF.md
# CAN Global Control Register Logic

This block holds the eight command and mode bits that steer a CAN controller as a whole, and it turns several of those bits into timed actions. A single write can cancel every pending buffer transmission, request an overload frame after the next received frame, pick the frame event that latches the time-trigger timer, or ask the protocol engine to enter the enabled or standby state. The actual enable state is reported separately, once the engine acknowledges it.

The block sits between a simple register bus and the CAN protocol engine. The engine supplies frame-event strobes, the running timer value and an enable acknowledge. The block returns a clear pulse for the per-buffer enable registers, an overload request, a capture strobe, and level signals for the operating modes. The bit-level protocol engine, the message buffers and the bit timing live elsewhere.

Top module: `can_gctl_top`

## Requirements
- R1: After reset, the control register reads 0x00, the stamp reads 0x0000, and every output is 0.
- R2: The control register sits at address 0. Its bit 7 is abort, bit 6 overload, bit 5 time-triggered mode, bit 4 capture select, bit 3 listen-only, bit 2 test, bit 1 enable command and bit 0 soft reset. A write stores the value, and a read returns it. `mode_ttc`, `mode_listen`, `mode_test` and `en_cmd` follow bits 5, 3, 2 and 1 from the cycle after the write.
- R3: The abort bit keeps its value until it is written again. A write that takes bit 7 from 0 to 1 produces a `buf_en_clr` pulse one cycle long in the cycle after the write. A write that finds bit 7 already at 1 produces no pulse.
- R4: A write with bit 6 = 1 raises `ovl_req` in the next cycle. `ovl_req` stays high until the cycle after `evt_rx_done`, then falls, while bit 6 still reads 1. A write with bit 6 = 0 also drops it.
- R5: With bit 5 = 1 and bit 4 = 0, an `evt_sof` strobe copies `tmr_value` into the stamp, and `ts_strobe` pulses in the cycle the stamp changes. Address 2 reads stamp bits 7:0 and address 3 reads stamp bits 15:8.
- R6: With bit 5 = 1 and bit 4 = 1, the capture happens on `evt_eof_last`, and `evt_sof` has no effect.
- R7: With bit 5 = 0, neither event captures: the stamp keeps its value and `ts_strobe` stays 0.
- R8: `en_status` (also bit 0 at address 1) equals `eng_en_ack` delayed by ACK_STAGES clocks (default 1). Writing the enable bit alone does not change it.
- R9: A control write with bit 0 = 1 loads the reset values in the next cycle. The control register reads 0x00 (bit 0 included), the stamp is 0, `ovl_req`, `ts_strobe` and `en_status` are 0, and no abort pulse is produced even if bit 7 is set in the same data. `en_status` then follows the acknowledge again.
- R10: A control write and a frame event in the same cycle are judged against the control bits held before that write. An arming overload write that coincides with `evt_rx_done` leaves `ovl_req` high. A write that sets bit 5 together with `evt_sof` captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| tmr_value | input | TMR_W | Running time-trigger timer |
| evt_sof | input | 1 | Start-of-frame strobe from the engine |
| evt_eof_last | input | 1 | Last end-of-frame bit strobe |
| evt_rx_done | input | 1 | Frame received strobe |
| eng_en_ack | input | 1 | Engine's enabled-state acknowledge |
| buf_en_clr | output | 1 | Clear pulse for the buffer-enable registers |
| ovl_req | output | 1 | Overload frame request to the engine |
| ts_strobe | output | 1 | Pulses when the stamp is captured |
| mode_ttc | output | 1 | Time-triggered mode |
| mode_listen | output | 1 | Listen-only mode |
| mode_test | output | 1 | Test mode |
| en_cmd | output | 1 | Enable command toward the engine |
| en_status | output | 1 | Acknowledged enable state |

## Verification
Two functions can fall in the same cycle: a register write and a frame event that acts on the same bits. The first case is an overload arm write in the cycle of `evt_rx_done`. The second is a write that sets time-triggered mode in the cycle of `evt_sof`. The bench drives each pair on one clock edge and expects the values R10 gives: the request stays up and no stamp is taken. A behavioural reference model applies the older control value to events on every clock, and random traffic mixes writes, soft resets and events so that many such collisions also occur by chance.

// File: rtl/can_gctl_pkg.sv
`timescale 1ns/1ps
package can_gctl_pkg;

   // Control byte layout, MSB first; the struct order is the bit order.
   typedef struct packed {
      logic abort;
      logic ovld;
      logic ttc;
      logic sync_eof;
      logic listen;
      logic test;
      logic ena;
      logic srst;
   } ctrl_t;

   localparam int unsigned CTRL_W      = 8;
   localparam int unsigned ADDR_CTRL   = 0;
   localparam int unsigned ADDR_STATUS = 1;
   localparam int unsigned ADDR_STAMP  = 2;

endpackage

// File: rtl/can_gctl_regs.sv
`timescale 1ns/1ps
module can_gctl_regs
   import can_gctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CTRL_W-1:0] bus_wdata,
   output ctrl_t             ctrl_q,
   output logic              ctrl_wr,
   output logic              soft_rst,
   output logic              clr_pulse
);

   ctrl_t wr_val;

   assign ctrl_wr  = bus_we && (bus_addr == ADDR_W'(ADDR_CTRL));
   assign wr_val   = ctrl_t'(bus_wdata);
   assign soft_rst = ctrl_wr && wr_val.srst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         clr_pulse <= 1'b0;
      end else if (soft_rst) begin
         ctrl_q    <= '0;
         clr_pulse <= 1'b0;
      end else begin
         clr_pulse <= ctrl_wr && wr_val.abort && !ctrl_q.abort;
         if (ctrl_wr) begin
            ctrl_q      <= wr_val;
            ctrl_q.srst <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/can_gctl_ovl.sv
`timescale 1ns/1ps
module can_gctl_ovl (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic ctrl_wr,
   input  logic wr_ovld,
   input  logic rx_done,
   output logic ovl_req
);

   // Priority: soft reset, then a control write, then the served frame.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovl_req <= 1'b0;
      else if (soft_rst)
         ovl_req <= 1'b0;
      else if (ctrl_wr)
         ovl_req <= wr_ovld;
      else if (rx_done)
         ovl_req <= 1'b0;
   end

endmodule

// File: rtl/can_gctl_stamp.sv
`timescale 1ns/1ps
module can_gctl_stamp #(
   parameter int unsigned TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             ttc,
   input  logic             sync_eof,
   input  logic             evt_sof,
   input  logic             evt_eof_last,
   input  logic [TMR_W-1:0] tmr_value,
   output logic [TMR_W-1:0] stamp_q,
   output logic             strobe
);

   logic hit;

   assign hit = ttc && (sync_eof ? evt_eof_last : evt_sof);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stamp_q <= '0;
         strobe  <= 1'b0;
      end else if (soft_rst) begin
         stamp_q <= '0;
         strobe  <= 1'b0;
      end else begin
         strobe <= hit;
         if (hit) stamp_q <= tmr_value;
      end
   end

endmodule

// File: rtl/can_gctl_enable.sv
`timescale 1ns/1ps
module can_gctl_enable #(
   parameter int unsigned ACK_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic ack,
   output logic en_status
);

   generate
      if (ACK_STAGES == 1) begin : g_direct
         logic en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        en_q <= 1'b0;
            else if (soft_rst) en_q <= 1'b0;
            else               en_q <= ack;
         end
         assign en_status = en_q;
      end else begin : g_chain
         logic [ACK_STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pipe <= '0;
            else if (soft_rst) pipe <= '0;
            else               pipe <= {pipe[ACK_STAGES-2:0], ack};
         end
         assign en_status = pipe[ACK_STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/can_gctl_top.sv
`timescale 1ns/1ps
module can_gctl_top
   import can_gctl_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned TMR_W      = 16,
   parameter int unsigned ACK_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [TMR_W-1:0]  tmr_value,
   input  logic              evt_sof,
   input  logic              evt_eof_last,
   input  logic              evt_rx_done,
   input  logic              eng_en_ack,
   output logic              buf_en_clr,
   output logic              ovl_req,
   output logic              ts_strobe,
   output logic              mode_ttc,
   output logic              mode_listen,
   output logic              mode_test,
   output logic              en_cmd,
   output logic              en_status
);

   localparam int unsigned NBYTES = TMR_W / 8;

   generate
      if (TMR_W < 8 || (TMR_W % 8) != 0) begin : g_bad_tmr
         $error("can_gctl_top: TMR_W must be a nonzero multiple of 8");
      end
      if (ACK_STAGES < 1) begin : g_bad_ack
         $error("can_gctl_top: ACK_STAGES must be at least 1");
      end
      if ((ADDR_STAMP + NBYTES) > (1 << ADDR_W)) begin : g_bad_addr
         $error("can_gctl_top: ADDR_W too narrow for the stamp bytes");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [7:0]       ctrl_bits;
   logic             ctrl_wr;
   logic             soft_rst;
   logic [TMR_W-1:0] stamp_q;
   logic [7:0]       stamp_byte [NBYTES];

   can_gctl_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .ctrl_q    (ctrl_q),
      .ctrl_wr   (ctrl_wr),
      .soft_rst  (soft_rst),
      .clr_pulse (buf_en_clr)
   );

   can_gctl_ovl u_ovl (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .ctrl_wr  (ctrl_wr),
      .wr_ovld  (bus_wdata[6]),
      .rx_done  (evt_rx_done),
      .ovl_req  (ovl_req)
   );

   can_gctl_stamp #(.TMR_W(TMR_W)) u_stamp (
      .clk          (clk),
      .rst_n        (rst_n),
      .soft_rst     (soft_rst),
      .ttc          (ctrl_q.ttc),
      .sync_eof     (ctrl_q.sync_eof),
      .evt_sof      (evt_sof),
      .evt_eof_last (evt_eof_last),
      .tmr_value    (tmr_value),
      .stamp_q      (stamp_q),
      .strobe       (ts_strobe)
   );

   can_gctl_enable #(.ACK_STAGES(ACK_STAGES)) u_enable (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .ack       (eng_en_ack),
      .en_status (en_status)
   );

   assign ctrl_bits   = ctrl_q;
   assign mode_ttc    = ctrl_q.ttc;
   assign mode_listen = ctrl_q.listen;
   assign mode_test   = ctrl_q.test;
   assign en_cmd      = ctrl_q.ena;

   generate
      for (genvar gi = 0; gi < NBYTES; gi++) begin : g_bytes
         assign stamp_byte[gi] = stamp_q[8*gi +: 8];
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADDR_CTRL))   bus_rdata = ctrl_bits;
      if (bus_addr == ADDR_W'(ADDR_STATUS)) bus_rdata = {7'd0, en_status};
      for (int i = 0; i < NBYTES; i++) begin
         if (bus_addr == ADDR_W'(ADDR_STAMP + i)) bus_rdata = stamp_byte[i];
      end
   end

endmodule

// File: rtl/can_gctl_chk.sv
`timescale 1ns/1ps
module can_gctl_chk #(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned TMR_W      = 16,
   parameter int unsigned ACK_STAGES = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic              evt_rx_done,
   input logic              eng_en_ack,
   input logic [7:0]        ctrl_q,
   input logic [TMR_W-1:0]  stamp_q,
   input logic              ts_strobe,
   input logic              buf_en_clr,
   input logic              ovl_req,
   input logic              en_status
);

   logic wr_c, wr_s;
   assign wr_c = bus_we && (bus_addr == '0);
   assign wr_s = wr_c && bus_wdata[0];

   p_clr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      buf_en_clr |=> !buf_en_clr);

   p_clr_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      buf_en_clr |-> $past(wr_c && bus_wdata[7] && !bus_wdata[0] && !ctrl_q[7]));

   p_abort_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[7] && !wr_c) |=> ctrl_q[7]);

   p_ovl_served_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovl_req && evt_rx_done && !wr_c) |=> !ovl_req);

   p_strobe_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ts_strobe |-> $past(ctrl_q[5]));

   p_stamp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ts_strobe && !$past(wr_s)) |-> $stable(stamp_q));

   p_swres_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_s |=> (ctrl_q == 8'h00) && !ovl_req && !ts_strobe && !buf_en_clr && !en_status);

   generate
      if (ACK_STAGES == 1) begin : g_en_chk
         p_en_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(wr_s)) |-> (en_status == $past(eng_en_ack)));
      end
   endgenerate

endmodule

bind can_gctl_top can_gctl_chk #(
   .ADDR_W(ADDR_W), .TMR_W(TMR_W), .ACK_STAGES(ACK_STAGES)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_we      (bus_we),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .evt_rx_done (evt_rx_done),
   .eng_en_ack  (eng_en_ack),
   .ctrl_q      (ctrl_bits),
   .stamp_q     (stamp_q),
   .ts_strobe   (ts_strobe),
   .buf_en_clr  (buf_en_clr),
   .ovl_req     (ovl_req),
   .en_status   (en_status)
);

// File: tb/test_can_gctl_top.sv
`timescale 1ns/1ps
module test_can_gctl_top;

   localparam int ADDR_W = 4;
   localparam int TMR_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              bus_we;
   logic [ADDR_W-1:0] bus_addr;
   logic [7:0]        bus_wdata;
   logic [7:0]        bus_rdata;
   logic [TMR_W-1:0]  tmr_value;
   logic              evt_sof, evt_eof_last, evt_rx_done, eng_en_ack;
   logic              buf_en_clr, ovl_req, ts_strobe;
   logic              mode_ttc, mode_listen, mode_test, en_cmd, en_status;

   always #10 clk = ~clk;

   can_gctl_top #(.ADDR_W(ADDR_W), .TMR_W(TMR_W), .ACK_STAGES(1)) i_can_gctl_top (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_value(tmr_value),
      .evt_sof(evt_sof), .evt_eof_last(evt_eof_last), .evt_rx_done(evt_rx_done),
      .eng_en_ack(eng_en_ack), .buf_en_clr(buf_en_clr), .ovl_req(ovl_req),
      .ts_strobe(ts_strobe), .mode_ttc(mode_ttc), .mode_listen(mode_listen),
      .mode_test(mode_test), .en_cmd(en_cmd), .en_status(en_status)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference model, advanced on every rising edge.
   logic [7:0]  m_ctrl;
   logic [15:0] m_stamp;
   logic        m_clr, m_ovl, m_strobe, m_en;

   always @(posedge clk) begin : model
      bit wr, sw, hit;
      if (!rst_n) begin
         m_ctrl = 0; m_stamp = 0; m_clr = 0; m_ovl = 0; m_strobe = 0; m_en = 0;
      end else begin
         wr  = bus_we && (bus_addr == 0);
         sw  = wr && bus_wdata[0];
         hit = m_ctrl[5] && (m_ctrl[4] ? evt_eof_last : evt_sof);
         if (sw) begin
            m_ctrl = 0; m_stamp = 0; m_clr = 0; m_ovl = 0; m_strobe = 0; m_en = 0;
         end else begin
            m_clr = wr && bus_wdata[7] && !m_ctrl[7];
            if (wr) m_ovl = bus_wdata[6];
            else if (evt_rx_done) m_ovl = 0;
            m_strobe = hit;
            if (hit) m_stamp = tmr_value;
            m_en = eng_en_ack;
            if (wr) m_ctrl = bus_wdata & 8'hFE;
         end
      end
   end

   function automatic logic [7:0] m_read(input logic [ADDR_W-1:0] a);
      case (a)
         0:       return m_ctrl;
         1:       return {7'd0, m_en};
         2:       return m_stamp[7:0];
         3:       return m_stamp[15:8];
         default: return 8'h00;
      endcase
   endfunction

   // Compare every clock, 5 ns after the rising edge.
   always @(posedge clk) begin
      #5;
      if (rst_n && !done) begin
         check("R2 mode_ttc", mode_ttc, m_ctrl[5]);
         check("R2 mode_listen", mode_listen, m_ctrl[3]);
         check("R2 mode_test", mode_test, m_ctrl[2]);
         check("R2 en_cmd", en_cmd, m_ctrl[1]);
         check("R3 buf_en_clr", buf_en_clr, m_clr);
         check("R4 ovl_req", ovl_req, m_ovl);
         check("R5 ts_strobe", ts_strobe, m_strobe);
         check("R8 en_status", en_status, m_en);
         check(bus_addr == 0 ? "R2 rdata" : bus_addr == 1 ? "R8 rdata" : "R5 rdata",
               bus_rdata, m_read(bus_addr));
      end
   end

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 0;
   endtask

   task automatic evt(input int which);
      @(negedge clk);
      if (which == 0) evt_sof = 1;
      if (which == 1) evt_eof_last = 1;
      if (which == 2) evt_rx_done = 1;
      @(negedge clk);
      evt_sof = 0; evt_eof_last = 0; evt_rx_done = 0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; tmr_value = 0;
      evt_sof = 0; evt_eof_last = 0; evt_rx_done = 0; eng_en_ack = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 ctrl", bus_rdata, 8'h00);
      check("R1 outputs", {buf_en_clr, ovl_req, ts_strobe, mode_ttc, mode_listen,
                           mode_test, en_cmd, en_status}, 0);
      bus_addr = 2; #1 check("R1 stamp", bus_rdata, 8'h00);
      bus_addr = 0;

      // R2 write and read back
      wr(0, 8'h2E);
      check("R2 readback", bus_rdata, 8'h2E);
      check("R2 modes", {mode_ttc, mode_listen, mode_test, en_cmd}, 4'b1111);

      // R3 abort pulse only on a 0->1 write
      wr(0, 8'h80);
      check("R3 pulse", buf_en_clr, 1);
      @(negedge clk);
      check("R3 pulse ends", buf_en_clr, 0);
      wr(0, 8'h80);
      check("R3 no repeat", buf_en_clr, 0);
      check("R3 sticky", bus_rdata, 8'h80);

      // R4 overload request served by the next received frame
      wr(0, 8'h40);
      check("R4 raised", ovl_req, 1);
      evt(2);
      check("R4 dropped", ovl_req, 0);
      check("R4 bit kept", bus_rdata, 8'h40);

      // R10 arming write in the same cycle as rx_done
      @(negedge clk);
      bus_we = 1; bus_addr = 0; bus_wdata = 8'h40; evt_rx_done = 1;
      @(negedge clk);
      bus_we = 0; evt_rx_done = 0;
      check("R10 ovl stays", ovl_req, 1);

      // R5 capture at start of frame
      wr(0, 8'h20);
      tmr_value = 16'h1234;
      evt(0);
      check("R5 strobe", ts_strobe, 1);
      bus_addr = 2; #1 check("R5 low", bus_rdata, 8'h34);
      bus_addr = 3; #1 check("R5 high", bus_rdata, 8'h12);
      tmr_value = 16'h5555;
      evt(1);
      check("R5 eof ignored", ts_strobe, 0);
      check("R5 stamp kept", bus_rdata, 8'h12);

      // R6 capture at last end-of-frame bit
      wr(0, 8'h30);
      tmr_value = 16'hBEEF;
      evt(1);
      check("R6 strobe", ts_strobe, 1);
      bus_addr = 2; #1 check("R6 low", bus_rdata, 8'hEF);
      tmr_value = 16'h0F0F;
      evt(0);
      check("R6 sof ignored", ts_strobe, 0);
      check("R6 stamp kept", bus_rdata, 8'hEF);

      // R7 no capture outside time-triggered mode
      wr(0, 8'h10);
      evt(0); check("R7 sof", ts_strobe, 0);
      evt(1); check("R7 eof", ts_strobe, 0);
      bus_addr = 3; #1 check("R7 stamp kept", bus_rdata, 8'hBE);

      // R10 mode-setting write in the same cycle as start of frame
      wr(0, 8'h00);
      @(negedge clk);
      bus_we = 1; bus_addr = 0; bus_wdata = 8'h20; evt_sof = 1;
      @(negedge clk);
      bus_we = 0; evt_sof = 0;
      check("R10 no capture", ts_strobe, 0);
      bus_addr = 3; #1 check("R10 stamp kept", bus_rdata, 8'hBE);

      // R8 enable status follows only the acknowledge
      wr(0, 8'h02);
      check("R8 cmd without ack", en_status, 0);
      eng_en_ack = 1;
      @(negedge clk);
      check("R8 ack seen", en_status, 1);
      bus_addr = 1; #1 check("R8 status read", bus_rdata, 8'h01);
      eng_en_ack = 0;
      @(negedge clk);
      check("R8 ack dropped", en_status, 0);

      // R9 soft reset wins over abort in the same data
      eng_en_ack = 1;
      wr(0, 8'h7E);
      wr(0, 8'hC1);
      bus_addr = 0; #1 check("R9 ctrl", bus_rdata, 8'h00);
      check("R9 outputs", {buf_en_clr, ovl_req, ts_strobe, en_status}, 0);
      bus_addr = 3; #1 check("R9 stamp", bus_rdata, 8'h00);
      @(negedge clk);
      check("R9 resumes", en_status, 1);

      // Mixed random traffic, compared against the model each clock
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         bus_we       = ($urandom % 6) == 0;
         bus_addr     = ADDR_W'($urandom % 5);
         bus_wdata    = 8'($urandom);
         bus_wdata[0] = ($urandom % 20) == 0;
         tmr_value    = 16'($urandom);
         evt_sof      = ($urandom % 5) == 0;
         evt_eof_last = ($urandom % 5) == 0;
         evt_rx_done  = ($urandom % 5) == 0;
         eng_en_ack   = ($urandom % 3) != 0;
      end
      @(negedge clk);
      bus_we = 0; evt_sof = 0; evt_eof_last = 0; evt_rx_done = 0;
      @(negedge clk);
      done = 1;
      summary();
      $finish;
   end

endmodule